// File: doc/BRIEF.md
# Transaction Time-out Counter

This block guards a serial-bus transaction against hanging. When the bus controller begins a transaction it pulses a start input; when the transaction finishes it pulses a done input. Between the two, a slow tick decrements a down counter. The tick is cut from the system clock by a divider, and its default setting gives 57.6 kHz from a 7.3728 MHz clock. If the counter runs out before the done pulse arrives, the block raises a single-cycle time-out pulse and goes idle. Recovering the bus after a time-out is left to the caller.

The interval comes from one configuration byte. Bit 0 of the byte switches the watchdog on (1) or off (0). The remaining upper bits set the high part of the counter on each reload. The lower part of the counter is always reloaded with ones, so the shortest interval is one full sweep of the low field. The divider is restarted at every reload, which makes the latency from start to time-out an exact number of clock cycles.

Top module: `xfer_watchdog`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `timeout_pulse` stays 0.
- R2: On a start, the counter loads with `cfg_byte[REG_W-1:1]` in its top `CNT_W-LOW_BITS` bits and ones in its low `LOW_BITS` bits, giving a reload value V. With bit 0 held at 1, `timeout_pulse` is high in the cycle after the clock edge that falls exactly (V+1)*TICK_DIV edges after the edge that sampled the start.
- R3: `timeout_pulse` lasts exactly one cycle. After it, no further pulse comes until a new start.
- R4: While `cfg_byte[0]` is 0, neither the counter nor the tick divider advances, and no time-out is issued.
- R5: If `cfg_byte[0]` is cleared for N clock edges during a transaction, the time-out is delayed by exactly N cycles.
- R6: A done pulse sampled before expiry ends the transaction, and no time-out follows.
- R7: A done pulse sampled on the same edge as the expiring tick wins: no time-out is issued.
- R8: A start sampled while a transaction is in progress reloads the counter and restarts the full interval from that edge.
- R9: When start and done are sampled on the same edge, start wins and a new interval begins.
- R10: Changes to the upper bits of `cfg_byte` after the start edge do not alter the interval that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | REG_W | Bit 0 enables the watchdog; the upper bits set the high part of the reload value |
| xfer_start | input | 1 | One-cycle pulse: a transaction begins |
| xfer_done | input | 1 | One-cycle pulse: the transaction has finished |
| timeout_pulse | output | 1 | One-cycle pulse: the interval expired before done |

## Verification
The hardest case to reach is a done pulse that lands on exactly the same edge as the expiring tick. A small bench configuration (8-bit counter, 3 low bits, divide by 3) makes every latency a short, exactly computable cycle count. Because of that, the bench can place done on the single critical edge, place a pause in the enable bit, or place a restart on a known edge. The same configuration allows a full sweep of all upper-field values, with each measured latency compared against (V+1)*TICK_DIV.

// File: rtl/xwd_pkg.sv
package xwd_pkg;

  // Reload word: upper field shifted above a low field of all ones.
  function automatic logic [31:0] compose_reload(input logic [31:0] upper,
                                                 input int          low_bits);
    return (upper << low_bits) | ((32'd1 << low_bits) - 32'd1);
  endfunction

  // Width of a counter that covers 0 .. div-1, never below one bit.
  function automatic int div_width(input int div);
    return (div <= 2) ? 1 : $clog2(div);
  endfunction

endpackage

// File: rtl/xwd_tick_div.sv
module xwd_tick_div #(
  parameter int TICK_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int DW = xwd_pkg::div_width(TICK_DIV);
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (clear)  phase_q <= '0;
    else if (tick)   phase_q <= '0;
    else if (run)    phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/xwd_down_cnt.sv
module xwd_down_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] value,
  output logic             is_zero
);
  logic [CNT_W-1:0] cnt_q;

  assign value   = cnt_q;
  assign is_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (dec)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/xwd_ctrl.sv
module xwd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  input  logic tick,
  input  logic is_zero,
  output logic active,
  output logic load,
  output logic dec,
  output logic expire
);
  logic active_q;

  assign active = active_q;
  assign load   = start;
  // start and done both take precedence over an expiring tick
  assign expire = active_q && tick && is_zero && !start && !done;
  assign dec    = tick && !is_zero && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_q <= 1'b0;
    else if (start)   active_q <= 1'b1;
    else if (done)    active_q <= 1'b0;
    else if (expire)  active_q <= 1'b0;
  end
endmodule

// File: rtl/xfer_watchdog.sv
module xfer_watchdog #(
  parameter  int CNT_W    = 16,
  parameter  int LOW_BITS = 9,
  parameter  int TICK_DIV = 128,
  localparam int UP_W     = CNT_W - LOW_BITS,
  localparam int REG_W    = UP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] cfg_byte,
  input  logic             xfer_start,
  input  logic             xfer_done,
  output logic             timeout_pulse
);
  logic             enable_w;
  logic [UP_W-1:0]  upper_w;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] count_w;
  logic             zero_w;
  logic             tick_w;
  logic             active_w;
  logic             load_w;
  logic             dec_w;
  logic             expire_w;
  logic             pulse_q;

  assign enable_w = cfg_byte[0];
  assign upper_w  = cfg_byte[REG_W-1:1];
  assign reload_w = CNT_W'(xwd_pkg::compose_reload(32'(upper_w), LOW_BITS));

  xwd_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (xfer_start),
    .run   (active_w && enable_w),
    .tick  (tick_w)
  );

  xwd_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_w),
    .load_val (reload_w),
    .dec      (dec_w),
    .value    (count_w),
    .is_zero  (zero_w)
  );

  xwd_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (xfer_start),
    .done    (xfer_done),
    .tick    (tick_w),
    .is_zero (zero_w),
    .active  (active_w),
    .load    (load_w),
    .dec     (dec_w),
    .expire  (expire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= expire_w;
  end

  assign timeout_pulse = pulse_q;
endmodule

// File: rtl/xwd_checker.sv
module xwd_checker #(
  parameter int CNT_W    = 16,
  parameter int LOW_BITS = 9,
  parameter int REG_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] cfg_byte,
  input logic             xfer_start,
  input logic             xfer_done,
  input logic             timeout_pulse,
  input logic             active_w,
  input logic             tick_w,
  input logic [CNT_W-1:0] count_w
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_w |=> !timeout_pulse);

  p_reload_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> count_w[CNT_W-1:LOW_BITS] == $past(cfg_byte[REG_W-1:1]));

  p_reload_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> &count_w[LOW_BITS-1:0]);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  p_tick_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |-> active_w && cfg_byte[0]);

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && !cfg_byte[0] && !xfer_start) |=> $stable(count_w));

  p_done_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_start) |=> !timeout_pulse && !active_w);

  p_start_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> active_w && !timeout_pulse);
endmodule

bind xfer_watchdog xwd_checker #(
  .CNT_W(CNT_W), .LOW_BITS(LOW_BITS), .REG_W(REG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_byte      (cfg_byte),
  .xfer_start    (xfer_start),
  .xfer_done     (xfer_done),
  .timeout_pulse (timeout_pulse),
  .active_w      (active_w),
  .tick_w        (tick_w),
  .count_w       (count_w)
);

// File: tb/xfer_watchdog_bench.sv
module xfer_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int LOW_BITS   = 3;
  localparam int TICK_DIV   = 3;
  localparam int UP_W       = CNT_W - LOW_BITS;
  localparam int REG_W      = UP_W + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [REG_W-1:0] cfg_byte = '0;
  logic             xfer_start = 1'b0;
  logic             xfer_done = 1'b0;
  logic             timeout_pulse;

  int cyc = 0;
  int pulse_cnt = 0;
  int last_pulse = -1;
  int checks = 0;
  int fails = 0;
  int t0 = 0;
  int base = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_watchdog #(.CNT_W(CNT_W), .LOW_BITS(LOW_BITS), .TICK_DIV(TICK_DIV)) u_xfer_watchdog (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .timeout_pulse(timeout_pulse)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (timeout_pulse) begin
    pulse_cnt  = pulse_cnt + 1;
    last_pulse = cyc;
  end

  // expected latency in edges from the start edge: (V+1)*TICK_DIV
  function automatic int exp_latency(input int upper);
    return ((upper << LOW_BITS) + (1 << LOW_BITS)) * TICK_DIV;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive start at a negedge; returns at the next negedge with cyc == t0
  task automatic kick(input int upper, input logic en);
    cfg_byte   = {UP_W'(upper), en};
    xfer_start = 1'b1;
    t0         = cyc + 1;
    base       = pulse_cnt;
    step(1);
    xfer_start = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(30);
    chk("R1 reset quiet", pulse_cnt, 0);

    // R2/R3: full sweep of the upper field
    for (int u = 0; u < (1 << UP_W); u++) begin
      kick(u, 1'b1);
      step(exp_latency(u) + 40);
      chk("R2 latency", last_pulse - t0, exp_latency(u));
      chk("R3 single pulse", pulse_cnt - base, 1);
    end

    // R4: disabled watchdog never fires
    kick(0, 1'b0);
    step(300);
    chk("R4 disabled no pulse", pulse_cnt - base, 0);
    xfer_done = 1'b1; step(1); xfer_done = 1'b0;

    // R5: pause 7 edges mid-interval
    kick(1, 1'b1);
    step(9);
    cfg_byte[0] = 1'b0;
    step(7);
    cfg_byte[0] = 1'b1;
    step(exp_latency(1) + 40);
    chk("R5 pause latency", last_pulse - t0, exp_latency(1) + 7);
    chk("R5 pause count", pulse_cnt - base, 1);

    // R6: done early
    kick(0, 1'b1);
    step(9);
    xfer_done = 1'b1; step(1); xfer_done = 1'b0;
    step(200);
    chk("R6 done early", pulse_cnt - base, 0);
    chk("R1 idle after done", pulse_cnt - base, 0);

    // R7: done on the expiring edge
    kick(0, 1'b1);
    step(exp_latency(0) - 1);
    xfer_done = 1'b1; step(1); xfer_done = 1'b0;
    step(100);
    chk("R7 done on expiry edge", pulse_cnt - base, 0);

    // R8: restart mid-interval
    kick(0, 1'b1);
    step(9);
    kick(0, 1'b1);
    step(exp_latency(0) + 40);
    chk("R8 restart latency", last_pulse - t0, exp_latency(0));
    chk("R8 restart count", pulse_cnt - base, 1);

    // R9: start and done together
    xfer_done = 1'b1;
    kick(2, 1'b1);
    xfer_done = 1'b0;
    step(exp_latency(2) + 40);
    chk("R9 start beats done", last_pulse - t0, exp_latency(2));
    chk("R9 count", pulse_cnt - base, 1);

    // R10: upper bits changed after start
    kick(0, 1'b1);
    step(1);
    cfg_byte = {UP_W'((1 << UP_W) - 1), 1'b1};
    step(exp_latency(0) + 40);
    chk("R10 reload latched", last_pulse - t0, exp_latency(0));
    step(200);
    chk("R3 no repeat pulse", pulse_cnt - base, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule